// File: doc/BRIEF.md
# H-Bridge Gate Control Logic

This block is the digital core that steers the four power switches of a full bridge driving a DC motor. Two direction lines pick the bridge state and a PWM line chops the low-side switches for speed control. Each half-bridge (leg) has an open-drain enable line: an external pull-up enables the leg, and the block pulls the line low itself to report a latched fault. All pin-level inputs pass through two-flop synchronisers before they are used.

Each leg carries its own fault latch. The latch is set by a high-side over-temperature flag or a low-side overcurrent flag. It is cleared only by a rising edge on that leg's own direction input. A supply undervoltage flag switches every gate off and freezes both latches until the supply returns. The block also enforces a programmable dead time inside each leg. It gates the current-sense enable and reports when the bridge is in standby.

Top module: `hbridge_ctrl`

## Requirements
- R1: Each leg follows only its own direction input (leg A, bit 0, uses `dir_a`; leg B, bit 1, uses `dir_b`). A high direction turns that leg's high-side gate on. A low direction turns its low-side gate on while PWM is high. So both high brakes to supply, both low brakes to ground, and A=1/B=0 or A=0/B=1 drive the motor one way or the other.
- R2: While the synchronised PWM input is low, every low-side gate is off and the high-side gates are unaffected. When PWM returns high, the low sides follow the direction inputs again.
- R3: While a leg's enable line reads low, both of that leg's gates are off and its `leg_hiz` bit is 1.
- R4: A high-side over-temperature or low-side overcurrent flag on a leg latches that leg off and drives its `diag_pull` bit to 1. The other leg is not affected.
- R5: A latched fault stays set after the fault flag is removed. It clears only on a low-to-high edge of that leg's direction input. If the flag is still present at that edge, the latch stays set.
- R6: While undervoltage is present, all four gates are off and `diag_pull` is 0. Neither latch may be set or cleared during that time. When the supply recovers, the legs resume from the current inputs and the held latch state.
- R7: `sense_en` is 1 when the synchronised `sense_dis` is low and 0 when it is high.
- R8: `standby` is 1 exactly when no latch is set and both direction inputs, PWM and both enable lines read low.
- R9: Within a leg, at least `DEAD_CYC` cycles with both gates off separate any gate turning off from any gate of that leg turning on. The high-side and low-side gates are never on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_a | input | 1 | Direction input for leg A |
| dir_b | input | 1 | Direction input for leg B |
| pwm | input | 1 | Speed chopping input for the low sides |
| en_line | input | 2 | Level read on each leg's open-drain enable/diag line (bit 0 = A) |
| hs_ot | input | 2 | High-side over-temperature flag per leg |
| ls_oc | input | 2 | Low-side overcurrent flag per leg |
| uv | input | 1 | Supply undervoltage flag |
| sense_dis | input | 1 | High disables the current-sense output |
| hs_gate | output | 2 | High-side gate enable per leg |
| ls_gate | output | 2 | Low-side gate enable per leg |
| leg_hiz | output | 2 | Leg output floating (no gate on) |
| diag_pull | output | 2 | Request to pull the leg's enable/diag line low |
| sense_en | output | 1 | Current-sense output enable |
| standby | output | 1 | Bridge idle with no latched fault |

## Verification
The bench pulls a fault flag on one leg and then removes it, so a latch that cleared when the flag dropped would release the leg too early. It gives a direction rising edge while an overcurrent flag is still present, which catches a design that lets the clear win over the set. It toggles direction and pulses a second leg's fault flag during undervoltage, which exposes a latch that is not frozen or a diag line that stays pulled during the dropout. A cycle-by-cycle monitor measures every off-to-on gap in each leg, so a direct switch between the high side and the low side, or a gap that is too short, is reported.

// File: rtl/hb_pkg.sv
package hb_pkg;

    localparam int NUM_LEGS = 2;
    // per leg: direction, enable, over-temp, overcurrent; shared: pwm, uv, sense_dis
    localparam int SYNC_W   = 4 * NUM_LEGS + 3;

    typedef enum logic [1:0] {
        LEG_OFF  = 2'd0,
        LEG_HS   = 2'd1,
        LEG_LS   = 2'd2,
        LEG_DEAD = 2'd3
    } leg_st_e;

    typedef struct packed {
        logic dir;
        logic pwm;
        logic en;
        logic ot;
        logic oc;
        logic uv;
    } leg_in_t;

    // Switch a leg should settle on, ignoring dead time.
    function automatic leg_st_e leg_target(leg_in_t li, logic faulted);
        if (li.uv || !li.en || faulted) return LEG_OFF;
        else if (li.dir)                return LEG_HS;
        else if (li.pwm)                return LEG_LS;
        else                            return LEG_OFF;
    endfunction

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/hb_leg.sv
module hb_leg
    import hb_pkg::*;
#(
    parameter int DEAD_CYC = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  leg_in_t in_i,
    output logic    hs_o,
    output logic    ls_o,
    output logic    fault_o,
    output logic    diag_o
);
    localparam int CW = $clog2(DEAD_CYC + 1);
    localparam logic [CW-1:0] DEAD_LOAD = CW'(DEAD_CYC - 1);
    localparam logic [CW-1:0] DEAD_MAX  = CW'(DEAD_CYC);

    logic          dir_q;
    logic          dir_rise;
    logic          fault_set;
    logic          fault_q;
    leg_st_e       st_q, st_n, tgt;
    logic [CW-1:0] cnt_q, cnt_n;

    assign dir_rise  = in_i.dir & ~dir_q;
    assign fault_set = in_i.ot | in_i.oc;

    // fault latch: frozen during undervoltage, set has priority over clear
    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q   <= 1'b0;
            fault_q <= 1'b0;
            diag_o  <= 1'b0;
        end else begin
            dir_q  <= in_i.dir;
            diag_o <= fault_q & ~in_i.uv;
            if (!in_i.uv) begin
                if (fault_set)     fault_q <= 1'b1;
                else if (dir_rise) fault_q <= 1'b0;
            end
        end
    end

    assign tgt = leg_target(in_i, fault_q);

    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        unique case (st_q)
            LEG_OFF: st_n = tgt;
            LEG_HS, LEG_LS: begin
                if (tgt != st_q) begin
                    st_n  = LEG_DEAD;
                    cnt_n = DEAD_LOAD;
                end
            end
            LEG_DEAD: begin
                if (cnt_q == '0) st_n  = tgt;
                else             cnt_n = cnt_q - 1'b1;
            end
            default: st_n = LEG_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= LEG_OFF;
            cnt_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
        end
    end

    assign hs_o    = (st_q == LEG_HS);
    assign ls_o    = (st_q == LEG_LS);
    assign fault_o = fault_q;

    // ---------------- checking ----------------
    logic          gate_on;
    logic          had_on;
    logic [CW-1:0] gap_q;
    assign gate_on = hs_o | ls_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q  <= '0;
            had_on <= 1'b0;
        end else begin
            if (gate_on) begin
                gap_q  <= '0;
                had_on <= 1'b1;
            end else if (gap_q < DEAD_MAX) begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    AST_DEAD_GAP: assert property (@(posedge clk) disable iff (rst)
        ($rose(gate_on) && had_on) |-> (gap_q >= DEAD_MAX)); // R9
    AST_UV_GATES_OFF: assert property (@(posedge clk) disable iff (rst)
        in_i.uv |=> (!hs_o && !ls_o)); // R6
    AST_UV_NO_DIAG: assert property (@(posedge clk) disable iff (rst)
        in_i.uv |=> !diag_o); // R6
    AST_UV_HOLD_LATCH: assert property (@(posedge clk) disable iff (rst)
        in_i.uv |=> $stable(fault_q)); // R6
    AST_PWM_LS_OFF: assert property (@(posedge clk) disable iff (rst)
        !in_i.pwm |=> !ls_o); // R2
    AST_EN_LOW_OFF: assert property (@(posedge clk) disable iff (rst)
        !in_i.en |=> (!hs_o && !ls_o)); // R3
    AST_FAULT_LATCH: assert property (@(posedge clk) disable iff (rst)
        (fault_set && !in_i.uv) |=> fault_q); // R4
    AST_FAULT_OFF: assert property (@(posedge clk) disable iff (rst)
        fault_q |=> (!hs_o && !ls_o)); // R4
    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (fault_q && !dir_rise) |=> fault_q); // R5
endmodule

// File: rtl/hbridge_ctrl.sv
module hbridge_ctrl
    import hb_pkg::*;
#(
    parameter int DEAD_CYC = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       dir_a,
    input  logic       dir_b,
    input  logic       pwm,
    input  logic [1:0] en_line,
    input  logic [1:0] hs_ot,
    input  logic [1:0] ls_oc,
    input  logic       uv,
    input  logic       sense_dis,
    output logic [1:0] hs_gate,
    output logic [1:0] ls_gate,
    output logic [1:0] leg_hiz,
    output logic [1:0] diag_pull,
    output logic       sense_en,
    output logic       standby
);
    logic [SYNC_W-1:0]   raw, sy;
    logic [NUM_LEGS-1:0] dir_s, en_s, ot_s, oc_s, fault_v;
    logic                pwm_s, uv_s, sdis_s;

    assign raw = {dir_b, dir_a, en_line, hs_ot, ls_oc, pwm, uv, sense_dis};

    hb_sync #(.W(SYNC_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (sy)
    );

    assign {dir_s, en_s, ot_s, oc_s, pwm_s, uv_s, sdis_s} = sy;

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        leg_in_t li;
        assign li = '{dir: dir_s[g], pwm: pwm_s, en: en_s[g],
                      ot: ot_s[g], oc: oc_s[g], uv: uv_s};
        hb_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
            .clk     (clk),
            .rst     (rst),
            .in_i    (li),
            .hs_o    (hs_gate[g]),
            .ls_o    (ls_gate[g]),
            .fault_o (fault_v[g]),
            .diag_o  (diag_pull[g])
        );
    end

    assign leg_hiz  = ~hs_gate & ~ls_gate;
    assign sense_en = ~sdis_s;
    assign standby  = ~|fault_v & ~|dir_s & ~pwm_s & ~|en_s;
endmodule

// File: tb/sim_hbridge_ctrl.sv
`timescale 1ns/1ps
module sim_hbridge_ctrl;
    localparam int DEAD = 4;
    localparam int SETTLE = 14;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dir_a = 0, dir_b = 0, pwm = 0, uv = 0, sense_dis = 0;
    logic [1:0] en_ext = 2'b00, hs_ot = 2'b00, ls_oc = 2'b00;
    logic [1:0] en_line, hs_gate, ls_gate, leg_hiz, diag_pull;
    logic sense_en, standby;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    // open-drain line: external pull-up gated by the block's own pull-down
    assign en_line = en_ext & ~diag_pull;

    hbridge_ctrl #(.DEAD_CYC(DEAD)) u0 (
        .clk(clk), .rst(rst), .dir_a(dir_a), .dir_b(dir_b), .pwm(pwm),
        .en_line(en_line), .hs_ot(hs_ot), .ls_oc(ls_oc), .uv(uv),
        .sense_dis(sense_dis), .hs_gate(hs_gate), .ls_gate(ls_gate),
        .leg_hiz(leg_hiz), .diag_pull(diag_pull), .sense_en(sense_en),
        .standby(standby)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // R9 monitor: off gap before every gate turn-on in a leg
    int  off_cnt [2] = '{0, 0};
    logic prev_on [2] = '{1'b0, 1'b0};
    logic seen_fall [2] = '{1'b0, 1'b0};
    always @(posedge clk) begin
        #1;
        if (!rst) begin
            for (int l = 0; l < 2; l++) begin
                logic on;
                on = hs_gate[l] | ls_gate[l];
                if (hs_gate[l] && ls_gate[l]) chk("R9 overlap", 8'd1, 8'd0);
                if (on && !prev_on[l] && seen_fall[l])
                    chk("R9 dead gap", (off_cnt[l] >= DEAD) ? 8'd1 : 8'd0, 8'd1);
                if (prev_on[l] && !on) seen_fall[l] = 1'b1;
                off_cnt[l] = on ? 0 : off_cnt[l] + 1;
                prev_on[l] = on;
            end
        end
    end

    task automatic t_reset;
        ticks(3);
        chk("R1 reset hs", {6'b0, hs_gate}, 8'h00);
        chk("R1 reset ls", {6'b0, ls_gate}, 8'h00);
        chk("R4 reset diag", {6'b0, diag_pull}, 8'h00);
    endtask

    task automatic t_modes;
        en_ext = 2'b11; pwm = 1;
        dir_a = 1; dir_b = 0; ticks(SETTLE);
        chk("R1 cw hs", {6'b0, hs_gate}, 8'h01);
        chk("R1 cw ls", {6'b0, ls_gate}, 8'h02);
        dir_a = 0; dir_b = 1; ticks(SETTLE);
        chk("R1 ccw hs", {6'b0, hs_gate}, 8'h02);
        chk("R1 ccw ls", {6'b0, ls_gate}, 8'h01);
        dir_a = 1; dir_b = 1; ticks(SETTLE);
        chk("R1 brake vcc", {4'b0, hs_gate, ls_gate}, 8'h0C);
        dir_a = 0; dir_b = 0; ticks(SETTLE);
        chk("R1 brake gnd", {4'b0, hs_gate, ls_gate}, 8'h03);
    endtask

    task automatic t_pwm;
        dir_a = 0; dir_b = 1; ticks(SETTLE);
        pwm = 0; ticks(SETTLE);
        chk("R2 pwm low ls", {6'b0, ls_gate}, 8'h00);
        chk("R2 pwm low hs kept", {6'b0, hs_gate}, 8'h02);
        pwm = 1; ticks(SETTLE);
        chk("R2 pwm back ls", {6'b0, ls_gate}, 8'h01);
    endtask

    task automatic t_enable;
        en_ext = 2'b01; ticks(SETTLE);
        chk("R3 leg B gates", {6'b0, hs_gate[1], ls_gate[1]}, 8'h00);
        chk("R3 leg B hiz", {7'b0, leg_hiz[1]}, 8'h01);
        chk("R3 leg A kept", {7'b0, ls_gate[0]}, 8'h01);
        en_ext = 2'b11; ticks(SETTLE);
        chk("R3 leg B back", {7'b0, hs_gate[1]}, 8'h01);
    endtask

    task automatic t_fault;
        dir_a = 1; dir_b = 0; ticks(SETTLE);
        hs_ot[0] = 1; ticks(SETTLE);
        chk("R4 diag A", {6'b0, diag_pull}, 8'h01);
        chk("R4 leg A off", {7'b0, hs_gate[0]}, 8'h00);
        chk("R4 leg B kept", {7'b0, ls_gate[1]}, 8'h01);
        hs_ot[0] = 0; ticks(SETTLE);
        chk("R5 latched after removal", {6'b0, diag_pull}, 8'h01);
        chk("R5 leg A still off", {7'b0, hs_gate[0]}, 8'h00);
        dir_a = 0; ticks(6);
        dir_a = 1; ticks(SETTLE);
        chk("R5 cleared by rise", {6'b0, diag_pull}, 8'h00);
        chk("R5 leg A resumes", {7'b0, hs_gate[0]}, 8'h01);
    endtask

    task automatic t_fault_persist;
        ls_oc[1] = 1; ticks(SETTLE);
        chk("R4 diag B", {6'b0, diag_pull}, 8'h02);
        dir_b = 1; ticks(SETTLE);
        chk("R5 set wins over rise", {6'b0, diag_pull}, 8'h02);
        ls_oc[1] = 0; dir_b = 0; ticks(6);
        dir_b = 1; ticks(SETTLE);
        chk("R5 clear after removal", {6'b0, diag_pull}, 8'h00);
        chk("R5 leg B hs", {7'b0, hs_gate[1]}, 8'h01);
        dir_b = 0; ticks(SETTLE);
    endtask

    task automatic t_uv;
        hs_ot[0] = 1; ticks(SETTLE);
        hs_ot[0] = 0;
        uv = 1; ticks(SETTLE);
        chk("R6 uv gates", {4'b0, hs_gate, ls_gate}, 8'h00);
        chk("R6 uv diag", {6'b0, diag_pull}, 8'h00);
        dir_a = 0; hs_ot[1] = 1; ticks(6);
        dir_a = 1; hs_ot[1] = 0; ticks(SETTLE);
        uv = 0; ticks(SETTLE);
        chk("R6 latch held A", {6'b0, diag_pull}, 8'h01);
        chk("R6 resume leg B", {7'b0, ls_gate[1]}, 8'h01);
        dir_a = 0; ticks(6);
        dir_a = 1; ticks(SETTLE);
        chk("R6 clear after uv", {6'b0, diag_pull}, 8'h00);
        chk("R6 resume leg A", {7'b0, hs_gate[0]}, 8'h01);
    endtask

    task automatic t_sense;
        chk("R7 sense on", {7'b0, sense_en}, 8'h01);
        sense_dis = 1; ticks(4);
        chk("R7 sense off", {7'b0, sense_en}, 8'h00);
        sense_dis = 0; ticks(4);
        chk("R7 sense back", {7'b0, sense_en}, 8'h01);
    endtask

    task automatic t_standby;
        chk("R8 active", {7'b0, standby}, 8'h00);
        dir_a = 0; dir_b = 0; pwm = 0; en_ext = 2'b00; ticks(SETTLE);
        chk("R8 idle", {7'b0, standby}, 8'h01);
        ls_oc[0] = 1; ticks(6);
        ls_oc[0] = 0; ticks(SETTLE);
        chk("R8 fault blocks", {7'b0, standby}, 8'h00);
        dir_a = 1; ticks(6);
        dir_a = 0; ticks(SETTLE);
        chk("R8 idle again", {7'b0, standby}, 8'h01);
    endtask

    bit done = 0;

    initial begin
        ticks(4);
        rst = 0;
        t_reset();
        t_modes();
        t_pwm();
        t_enable();
        t_fault();
        t_fault_persist();
        t_uv();
        t_sense();
        t_standby();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule